// File: doc/BRIEF.md
# Sequential Page Read Sequencer

This block is the device-side read engine of a read-only page memory. A command decoder in front of it supplies a page index, a start column and a read mode, and pulses `start`. The engine then signals busy on an active-low ready line for a programmed access time. After that it hands out one byte per falling edge of the read strobe. A page is 528 bytes: columns 0 to 511 carry data and columns 512 to 527 form a spare area that always reads 0xFF. Pages are grouped 32 to a block, and the array holds 1024 blocks.

When the last column of a page has been read, the engine waits a short window. It then goes busy again and continues with the next page of the same block. In the data modes the next page starts at column 0. In the spare-only mode it starts at column 512, so only spare bytes are streamed. The stream stops after the last column of the last page in a block. Raising chip enable during the window after a page ends cancels the next page access. A reset command aborts any activity, holds busy for a reset time and leaves the engine idle. The array is a behavioural byte source. All times are counted in system clocks, and the read strobe and chip enable are sampled on the clock.

Top module: `page_stream_reader`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `ready` is 1, `dout_oe` is 0 and `err_cnt` is 0.
- R2: After `start` is accepted on a clock edge, `ready` is 0 for exactly ACCESS_CYC clock cycles and then returns to 1.
- R3: The start column depends on the mode code `mode_in`. Code 0 starts at `col_in`. Code 1 starts at 256 + `col_in`. Codes 2 and 3 start at 512 + `col_in[3:0]`.
- R4: Each falling edge of `re_n` seen while streaming puts the byte of the current column on `dout` on the next clock edge, then advances the column by one. A data byte at page p and column c (c < 512) equals p[7:0] XOR c[7:0] XOR (0x5A if c[8] is set, else 0x00).
- R5: Columns 512 to 527 always read as 0xFF.
- R6: After column 527 of a page whose index is not 31 modulo 32, `ready` stays 1 for GAP_CYC cycles. It then goes to 0 for ACCESS_CYC cycles, and streaming resumes on the next page at column 0 (codes 0 and 1) or column 512 (codes 2 and 3).
- R7: After column 527 of a page whose index is 31 modulo 32, no busy period follows, `ready` stays 1, and further read strobes produce no output.
- R8: If `ce_n` is high on a clock edge during the window after a page ends, the next page access is cancelled: `ready` stays 1 and later read strobes produce no output.
- R9: `dout_oe` is 1 only while `ce_n` is low, `re_n` is low and a byte has been handed out for the current strobe. It is 0 at all times while busy.
- R10: A `rst_cmd` pulse aborts any read or busy period. `ready` is 0 for exactly RESET_CYC cycles after the edge that samples it, and the engine is then idle with no output on read strobes.
- R11: A falling edge of `re_n` while busy is ignored: the column does not advance, and `err_cnt` increases by one, saturating at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a read with the address inputs |
| mode_in | input | 2 | Read mode code: 0 low data half, 1 high data half, 2 or 3 spare area |
| page_in | input | PAGE_W (15) | Page index within the array |
| col_in | input | HALF_W (8) | Start column offset within the area chosen by the mode |
| rst_cmd | input | 1 | One-cycle reset command pulse |
| ce_n | input | 1 | Chip enable, active low, sampled on the clock |
| re_n | input | 1 | Read strobe, active low, sampled on the clock |
| dout | output | 8 | Byte handed out by the last accepted strobe |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |
| ready | output | 1 | 1 when ready, 0 while busy |
| err_cnt | output | ERR_W (8) | Saturating count of read strobes received while busy |

## Verification
The hardest case to reach is the short window between the last column of a page and the next busy period. Only there does chip enable cancel the next access, and only there does `ready` stay high while the engine is still active. The bench reads a page out to column 527 one strobe at a time. It stops in the exact cycle after the final strobe and raises chip enable there, which is within the window. In other runs it counts the high cycles of `ready` to confirm the window length before the next busy period. Block ends are reached by starting one or two pages before a block boundary and streaming every byte up to it.

// File: rtl/page_stream_pkg.sv
// Shared types of the page read sequencer.
// Assumes: none beyond the parameters of the users of these types.
package page_stream_pkg;

    // Engine states; ACCESS and RESETTING are the busy states.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ACCESS    = 3'd1,
        ST_STREAM    = 3'd2,
        ST_GAP       = 3'd3,
        ST_RESETTING = 3'd4
    } eng_state_t;

endpackage

// File: rtl/page_byte_source.sv
// Behavioural byte source standing in for the read-only array.
// Data columns return a pattern derived from page and column. Spare columns
// return all ones. Assumes COL_W >= 9 so that column bit 8 exists.
module page_byte_source #(
    parameter int MAIN_BYTES = 512,
    parameter int COL_W      = 10
) (
    input  logic [7:0]       page_lo,
    input  logic [COL_W-1:0] col,
    output logic [7:0]       data
);
    // Pattern for data columns, constant 0xFF for spare columns.
    always_comb begin
        if (col >= COL_W'(MAIN_BYTES)) begin
            data = 8'hFF;
        end else begin
            data = page_lo ^ col[7:0] ^ (col[8] ? 8'h5A : 8'h00);
        end
    end
endmodule

// File: rtl/cycle_timer.sv
// Loadable down counter used for access, reset and end-of-page windows.
// A load on one edge followed by N further edges gives zero == 1 after the
// N-th of them, when the load value is N. Holds at zero.
module cycle_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load or count down, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/page_stream_reader.sv
// Sequential page read engine. It takes a page, start column and mode,
// signals busy for an access time and then hands out one byte per falling
// edge of re_n. It wraps to a mode-dependent column at each page end and
// stops at the end of the block.
// Assumes: ce_n and re_n are synchronous to clk. ACCESS_CYC, RESET_CYC and
// GAP_CYC are all at least 1.
module page_stream_reader
    import page_stream_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int BLOCK_PAGES = 32,
    parameter int NUM_BLOCKS  = 1024,
    parameter int ACCESS_CYC  = 350,
    parameter int RESET_CYC   = 300,
    parameter int GAP_CYC     = 2,
    parameter int ERR_W       = 8,
    localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
    localparam int COL_W      = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = $clog2(BLOCK_PAGES * NUM_BLOCKS),
    localparam int HALF_W     = $clog2(MAIN_BYTES / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode_in,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [HALF_W-1:0] col_in,
    input  logic              rst_cmd,
    input  logic              ce_n,
    input  logic              re_n,
    output logic [7:0]        dout,
    output logic              dout_oe,
    output logic              ready,
    output logic [ERR_W-1:0]  err_cnt
);
    localparam int BLK_W    = $clog2(BLOCK_PAGES);
    localparam int SPARE_W  = $clog2(SPARE_BYTES);
    localparam int T_MAX_AR = (ACCESS_CYC > RESET_CYC) ? ACCESS_CYC : RESET_CYC;
    localparam int T_MAX    = (T_MAX_AR > GAP_CYC) ? T_MAX_AR : GAP_CYC;
    localparam int TMR_W    = $clog2(T_MAX + 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

    eng_state_t        state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;
    logic              spare_q;
    logic [7:0]        dout_q;
    logic              have_q;
    logic [ERR_W-1:0]  err_q;
    logic              re_q;
    logic [COL_W-1:0]  start_col, wrap_col;
    logic [7:0]        src_byte;
    logic              re_fall, re_rise, busy_st, accept_start, take_byte;
    logic              last_col, last_page, tmr_zero, tmr_load;
    logic [TMR_W-1:0]  tmr_val;

    assign re_fall      = re_q & ~re_n;
    assign re_rise      = ~re_q & re_n;
    assign busy_st      = (state_q == ST_ACCESS) || (state_q == ST_RESETTING);
    assign accept_start = start && !busy_st;
    assign take_byte    = (state_q == ST_STREAM) && re_fall;
    assign last_col     = (col_q == LAST_COL);
    assign last_page    = (page_q[BLK_W-1:0] == {BLK_W{1'b1}});
    assign wrap_col     = spare_q ? COL_W'(MAIN_BYTES) : '0;

    // Map the mode code and column offset to an absolute start column.
    always_comb begin
        if (mode_in[1]) begin
            start_col = COL_W'(MAIN_BYTES) + COL_W'(col_in[SPARE_W-1:0]);
        end else if (mode_in[0]) begin
            start_col = COL_W'(MAIN_BYTES / 2) + COL_W'(col_in);
        end else begin
            start_col = COL_W'(col_in);
        end
    end

    // Next-state selection; the reset command wins over everything.
    always_comb begin
        state_d = state_q;
        if (rst_cmd) begin
            state_d = ST_RESETTING;
        end else if (accept_start) begin
            state_d = ST_ACCESS;
        end else begin
            case (state_q)
                ST_ACCESS:    if (tmr_zero) state_d = ST_STREAM;
                ST_RESETTING: if (tmr_zero) state_d = ST_IDLE;
                ST_STREAM:    if (take_byte && last_col)
                                  state_d = last_page ? ST_IDLE : ST_GAP;
                ST_GAP:       if (ce_n) state_d = ST_IDLE;
                              else if (tmr_zero) state_d = ST_ACCESS;
                default:      state_d = state_q;
            endcase
        end
    end

    // Timer reload on every state entry, value chosen by the new state.
    always_comb begin
        tmr_load = rst_cmd || (state_d != state_q);
        case (state_d)
            ST_RESETTING: tmr_val = TMR_W'(RESET_CYC - 1);
            ST_GAP:       tmr_val = TMR_W'(GAP_CYC - 1);
            default:      tmr_val = TMR_W'(ACCESS_CYC - 1);
        endcase
    end

    cycle_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    page_byte_source #(.MAIN_BYTES(MAIN_BYTES), .COL_W(COL_W)) u_src (
        .page_lo (page_q[7:0]),
        .col     (col_q),
        .data    (src_byte)
    );

    // State register and strobe history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            re_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            re_q    <= re_n;
        end
    end

    // Address, column and output byte handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q  <= '0;
            col_q   <= '0;
            spare_q <= 1'b0;
            dout_q  <= 8'h00;
            have_q  <= 1'b0;
        end else if (rst_cmd) begin
            have_q  <= 1'b0;
        end else if (accept_start) begin
            page_q  <= page_in;
            col_q   <= start_col;
            spare_q <= mode_in[1];
            have_q  <= 1'b0;
        end else if (take_byte) begin
            dout_q  <= src_byte;
            have_q  <= 1'b1;
            if (!last_col) begin
                col_q <= col_q + 1'b1;
            end else if (!last_page) begin
                page_q <= page_q + 1'b1;
                col_q  <= wrap_col;
            end
        end else if (re_rise || state_d == ST_ACCESS) begin
            have_q  <= 1'b0;
        end
    end

    // Count strobes that arrive while busy, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (busy_st && re_fall && err_q != {ERR_W{1'b1}}) begin
            err_q <= err_q + 1'b1;
        end
    end

    assign dout    = dout_q;
    assign dout_oe = !ce_n && !re_n && have_q;
    assign ready   = !busy_st;
    assign err_cnt = err_q;
endmodule

// File: rtl/page_stream_reader_chk.sv
// Property checker for the page read engine, attached by bind.
// Assumes the top-level signal names of page_stream_reader.
module page_stream_reader_chk #(
    parameter int MAIN_BYTES = 512,
    parameter int PAGE_BYTES = 528,
    parameter int COL_W      = 10,
    parameter int ERR_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_cmd,
    input logic             ready,
    input logic             dout_oe,
    input logic [7:0]       dout,
    input logic [ERR_W-1:0] err_cnt,
    input logic [COL_W-1:0] col_q,
    input logic             take_byte
);
    // R9: no output is driven while the engine is busy.
    a_r9_no_oe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> ready);

    // R10: the edge after a reset command always shows busy.
    a_r10_reset_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_cmd)) |-> !ready);

    // R11: the error count moves only after a busy cycle.
    a_r11_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && err_cnt != $past(err_cnt)) |-> !$past(ready));

    // R5: a byte taken from a spare column is 0xFF.
    a_r5_spare_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (take_byte && col_q >= COL_W'(MAIN_BYTES)) |=> (dout == 8'hFF));

    // R4: the column pointer never leaves the page.
    a_r4_col_range: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= COL_W'(PAGE_BYTES - 1));
endmodule

bind page_stream_reader page_stream_reader_chk #(
    .MAIN_BYTES (MAIN_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .COL_W      (COL_W),
    .ERR_W      (ERR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_cmd   (rst_cmd),
    .ready     (ready),
    .dout_oe   (dout_oe),
    .dout      (dout),
    .err_cnt   (err_cnt),
    .col_q     (col_q),
    .take_byte (take_byte)
);

// File: tb/page_stream_reader_test.sv
// Self-checking bench: streams whole pages and blocks in every mode and
// checks each byte, each busy length and the cancel and reset paths.
module page_stream_reader_test;
    localparam int A = 5;
    localparam int R = 3;
    localparam int G = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode_in = 2'd0;
    logic [14:0] page_in = '0;
    logic [7:0]  col_in = '0;
    logic        rst_cmd = 1'b0;
    logic        ce_n = 1'b0;
    logic        re_n = 1'b1;
    logic [7:0]  dout;
    logic        dout_oe;
    logic        ready;
    logic [7:0]  err_cnt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    page_stream_reader #(
        .ACCESS_CYC (A),
        .RESET_CYC  (R),
        .GAP_CYC    (G)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode_in (mode_in),
        .page_in (page_in),
        .col_in  (col_in),
        .rst_cmd (rst_cmd),
        .ce_n    (ce_n),
        .re_n    (re_n),
        .dout    (dout),
        .dout_oe (dout_oe),
        .ready   (ready),
        .err_cnt (err_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int page, input int col);
        if (col >= 512) return 8'hFF;
        return page[7:0] ^ col[7:0] ^ (col[8] ? 8'h5A : 8'h00);
    endfunction

    task automatic wait_busy(input string req, input int expn);
        int n = 0;
        while (!ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == expn, req, n, expn);
    endtask

    task automatic start_read(input int page, input int col, input int mode);
        @(negedge clk);
        page_in = page[14:0];
        col_in  = col[7:0];
        mode_in = mode[1:0];
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        wait_busy("R2", A);
    endtask

    task automatic read_byte(input logic [7:0] exp, input string req);
        re_n = 1'b0;
        @(negedge clk);
        chk(dout_oe == 1'b1, req, dout_oe, 1);
        chk(dout == exp, req, dout, exp);
        re_n = 1'b1;
        @(negedge clk);
        chk(dout_oe == 1'b0, "R9", dout_oe, 0);
    endtask

    task automatic page_turn();
        int n = 1;
        while (ready && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk(n == G, "R6", n, G);
        wait_busy("R6", A);
    endtask

    task automatic stream(input int page, input int col, input bit spare, input string req);
        int p = page;
        int c = col;
        while (1) begin
            for (int k = c; k < 528; k++) read_byte(exp_byte(p, k), req);
            if ((p % 32) == 31) break;
            page_turn();
            p++;
            c = spare ? 512 : 0;
        end
    endtask

    task automatic no_more(input string req);
        for (int i = 0; i < 8; i++) begin
            chk(ready == 1'b1, req, ready, 1);
            @(negedge clk);
        end
        re_n = 1'b0;
        @(negedge clk);
        chk(dout_oe == 1'b0, req, dout_oe, 0);
        re_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R1", ready, 1);
        chk(dout_oe == 1'b0, "R1", dout_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R1", ready, 1);
        chk(err_cnt == 8'd0, "R1", err_cnt, 0);

        // Spare-only mode across a whole block: R5, R6, R7.
        start_read(0, 3, 2);
        stream(0, 515, 1'b1, "R5");
        no_more("R7");

        // Low data half, three pages up to a block boundary: R3, R4, R6.
        start_read(93, 200, 0);
        stream(93, 200, 1'b0, "R4");
        no_more("R7");

        // High data half, then cancel by chip enable after the page: R3, R8, R9.
        start_read(5, 10, 1);
        read_byte(exp_byte(5, 266), "R3");
        re_n = 1'b0;
        @(negedge clk);
        chk(dout == exp_byte(5, 267), "R4", dout, exp_byte(5, 267));
        ce_n = 1'b1;
        #1;
        chk(dout_oe == 1'b0, "R9", dout_oe, 0);
        ce_n = 1'b0;
        re_n = 1'b1;
        @(negedge clk);
        for (int k = 268; k < 528; k++) read_byte(exp_byte(5, k), "R4");
        ce_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            chk(ready == 1'b1, "R8", ready, 1);
            @(negedge clk);
        end
        ce_n = 1'b0;
        no_more("R8");

        // Spare mode via code 3, wrap to column 512, then reset mid-stream: R3, R6, R10.
        start_read(40, 8'h1B, 3);
        for (int k = 523; k < 528; k++) read_byte(8'hFF, "R3");
        page_turn();
        read_byte(8'hFF, "R6");
        @(negedge clk);
        rst_cmd = 1'b1;
        @(negedge clk);
        rst_cmd = 1'b0;
        wait_busy("R10", R);
        no_more("R10");

        // Strobes during busy: ignored and counted: R11.
        @(negedge clk);
        page_in = 15'd300;
        col_in  = 8'd7;
        mode_in = 2'd0;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        re_n  = 1'b0;
        @(negedge clk);
        re_n  = 1'b1;
        @(negedge clk);
        re_n  = 1'b0;
        @(negedge clk);
        re_n  = 1'b1;
        @(negedge clk);
        while (!ready) @(negedge clk);
        chk(err_cnt == 8'd2, "R11", err_cnt, 2);
        read_byte(exp_byte(300, 7), "R11");

        // Reset during an access period: R10.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        rst_cmd = 1'b1;
        @(negedge clk);
        rst_cmd = 1'b0;
        wait_busy("R10", R);
        no_more("R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule